// File: doc/BRIEF.md
# Timeslot Load-Modulation Frame Transmitter

This block sends the card side of a reader/card exchange. The reply is sent by switching a subcarrier on and off. A request carries a payload word, a bit count, an acknowledge flag and the timestamp at which the reader's last frame ended. The block then waits a fixed gap, measured in ticks of the shared reference clock enable. After the gap it drives a modulation-enable line one bit per fixed-length timeslot.

Data bits are whitened with an external keystream. The block steps that keystream through a one-cycle advance strobe. While it waits, it moves the keystream forward past the slots that the gap covers, so that the keystream stays aligned with slot time.

An acknowledgement uses a much longer gap and sends one bit that is always high and is not whitened. Slot edges come from a running deadline that grows by exactly one slot length per bit, so slot edges never drift. A one-cycle done strobe marks the end of every transmission.

Top module: `lmtx_slot_tx`

## Requirements
- R1: After reset, `mod_en`, `busy`, `done` and `ks_adv` are all low.
- R2: For a data request (`req_ack`=0), `mod_en` stays low until the timestamp reaches `req_eof_ts`+70. The first bit is on `mod_en` from tick `req_eof_ts`+71.
- R3: Bit i of a frame whose first slot starts at tick T is held on `mod_en` from tick T+21·i+1 through tick T+21·i+20. Each slot is exactly 21 ticks, with no accumulated drift.
- R4: Bits are sent from bit 0 of `req_frame` upward. Each bit is XORed with `ks_bit` as seen after 2+i keystream advances counted from request acceptance.
- R5: A data request advances the keystream twice during the gap and once at the end of each bit slot, for a total of 2+`req_len` strobes.
- R6: When the last slot ends, `mod_en` is forced low and `done` pulses high for exactly one cycle. Both are seen by tick T+21·len+1.
- R7: An acknowledge request (`req_ack`=1) starts its slot 758 ticks after `req_eof_ts`. It drives `mod_en` high for one 21-tick slot whatever the keystream holds, ignores `req_frame` and `req_len`, and gives 36 advance strobes in total (35 during the gap, one after the bit).
- R8: `busy` rises the cycle after a request is accepted and falls together with `done`. A request presented while `busy` is high is ignored: the bits, the strobe count and the `done` count of the transmission in progress are unchanged.
- R9: A data request with `req_len`=0 drives no modulation. It gives only the two gap advances and pulses `done` by tick `req_eof_ts`+71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_now | input | TS_W | Free-running reference tick count shared with the receiver |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_eof_ts | input | TS_W | Tick at which the reader frame ended |
| req_frame | input | FRAME_W | Payload, bit 0 sent first |
| req_len | input | LEN_W | Number of payload bits |
| req_ack | input | 1 | 1 selects an acknowledge reply |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream advance strobe; the keystream steps at the edge where it is high |
| mod_en | output | 1 | Subcarrier modulation enable |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle end-of-transmission pulse |

## Verification
The bench starts its clock from the reader end-of-frame tick T0 (`req_eof_ts`) and from the gap, and works out the tick of every slot edge. The deadline reaches `mod_en` two register stages after the timestamp matches it. The bench therefore samples `mod_en` one tick after each slot start and again one tick before the slot end. It does the same for the end of the frame and for `done`. It samples every value at a negative edge, with the tick enable running every second cycle. This puts each sample a full cycle away from the transition it brackets.

The bench keeps its own copy of the keystream. From it, the bench computes the whitened bit expected after 2+i steps. It also counts advance strobes and `done` pulses from the state captured at acceptance.

// File: rtl/lmtx_pkg.sv
package lmtx_pkg;
    localparam int unsigned BIT_TICKS = 21;
    localparam int unsigned DATA_GAP  = 70;
    localparam int unsigned ACK_GAP   = 758;

    // keystream steps that fit into a gap before the first slot
    function automatic int unsigned gap_steps(input int unsigned gap);
        return gap / BIT_TICKS - 1;
    endfunction

    localparam int unsigned DATA_STEPS = gap_steps(DATA_GAP);
    localparam int unsigned ACK_STEPS  = gap_steps(ACK_GAP);
    localparam int unsigned STEP_W     = $clog2(ACK_STEPS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOAD,
        ST_SLOT
    } tx_state_e;
endpackage

// File: rtl/lmtx_deadline.sv
module lmtx_deadline #(
    parameter int TS_W = 16
) (
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] deadline,
    output logic            reached
);
    logic [TS_W-1:0] diff;
    // wrap-safe: deadline is reached once the difference is non-negative
    always_comb begin
        diff    = now - deadline;
        reached = ~diff[TS_W-1];
    end
endmodule

// File: rtl/lmtx_prefast.sv
module lmtx_prefast #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);
    logic [CNT_W-1:0] cnt;

    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (active)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/lmtx_shifter.sv
module lmtx_shifter #(
    parameter int FRAME_W = 32,
    parameter int LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               step,
    output logic               cur_bit,
    output logic               last,
    output logic               empty
);
    logic [FRAME_W-1:0] sr;
    logic [LEN_W-1:0]   left;

    assign cur_bit = sr[0];
    assign last    = (left == LEN_W'(1));
    assign empty   = (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            left <= '0;
        end else if (load) begin
            sr   <= frame_in;
            left <= len_in;
        end else if (step && !empty) begin
            sr   <= {1'b0, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/lmtx_slot_tx.sv
module lmtx_slot_tx
    import lmtx_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int FRAME_W = 32,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TS_W-1:0]    ts_now,
    input  logic               req_valid,
    input  logic [TS_W-1:0]    req_eof_ts,
    input  logic [FRAME_W-1:0] req_frame,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_ack,
    input  logic               ks_bit,
    output logic               ks_adv,
    output logic               mod_en,
    output logic               busy,
    output logic               done
);
    localparam logic [TS_W-1:0]   DATA_GAP_TS = TS_W'(DATA_GAP);
    localparam logic [TS_W-1:0]   ACK_GAP_TS  = TS_W'(ACK_GAP);
    localparam logic [TS_W-1:0]   SLOT_TS     = TS_W'(BIT_TICKS);
    localparam logic [STEP_W-1:0] DATA_PF     = STEP_W'(DATA_STEPS);
    localparam logic [STEP_W-1:0] ACK_PF      = STEP_W'(ACK_STEPS);

    tx_state_e       state;
    logic [TS_W-1:0] slot_end;
    logic            ack_q;
    logic            mod_q;
    logic            done_q;

    logic accept, reached, pf_active, sh_bit, sh_last, sh_empty, slot_over;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign slot_over = (state == ST_SLOT) && reached;

    lmtx_deadline #(.TS_W(TS_W)) u_dl (
        .now      (ts_now),
        .deadline (slot_end),
        .reached  (reached)
    );

    lmtx_prefast #(.CNT_W(STEP_W)) u_pf (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (req_ack ? ACK_PF : DATA_PF),
        .active   (pf_active)
    );

    lmtx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .frame_in (req_frame),
        .len_in   (req_ack ? LEN_W'(1) : req_len),
        .step     (slot_over),
        .cur_bit  (sh_bit),
        .last     (sh_last),
        .empty    (sh_empty)
    );

    // keystream steps: gap fast-forward, then one per finished slot
    assign ks_adv = ((state == ST_WAIT) && pf_active) || slot_over;
    assign mod_en = mod_q;
    assign busy   = (state != ST_IDLE);
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            slot_end <= '0;
            ack_q    <= 1'b0;
            mod_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ack_q    <= req_ack;
                        slot_end <= req_eof_ts + (req_ack ? ACK_GAP_TS : DATA_GAP_TS);
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!pf_active && reached) begin
                        if (sh_empty) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    mod_q    <= ack_q ? 1'b1 : (sh_bit ^ ks_bit);
                    slot_end <= slot_end + SLOT_TS;
                    state    <= ST_SLOT;
                end
                ST_SLOT: begin
                    if (reached) begin
                        if (sh_last) begin
                            mod_q  <= 1'b0;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_LOAD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lmtx_checker.sv
module lmtx_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mod_en,
    input logic ks_adv
);
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: modulation never active outside a transmission
    a_r6_mod_off_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mod_en);

    // R5: keystream only steps while transmitting
    a_r5_adv_when_busy: assert property (@(posedge clk) disable iff (rst)
        ks_adv |-> busy);

    // R8: accepted request raises busy next cycle
    a_r8_busy_after_req: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R8: busy falls only together with done
    a_r8_busy_falls_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: done coincides with idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind lmtx_slot_tx lmtx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mod_en    (mod_en),
    .ks_adv    (ks_adv)
);

// File: tb/sim_lmtx_slot_tx.sv
module sim_lmtx_slot_tx;
    localparam int TS_W = 16;
    localparam int FW   = 32;
    localparam int LW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TS_W-1:0] ts_now = '0;
    logic          tick_ph = 1'b0;
    logic          req_valid = 1'b0;
    logic [TS_W-1:0] req_eof_ts = '0;
    logic [FW-1:0] req_frame = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ack = 1'b0;
    logic          ks_bit, ks_adv, mod_en, busy, done;
    logic [6:0]    ks_lfsr = 7'h5B;

    int n_chk = 0;
    int n_fail = 0;
    int adv_cnt = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lmtx_slot_tx #(.TS_W(TS_W), .FRAME_W(FW), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst), .ts_now(ts_now), .req_valid(req_valid),
        .req_eof_ts(req_eof_ts), .req_frame(req_frame), .req_len(req_len),
        .req_ack(req_ack), .ks_bit(ks_bit), .ks_adv(ks_adv),
        .mod_en(mod_en), .busy(busy), .done(done)
    );

    assign ks_bit = ks_lfsr[0];

    function automatic logic [6:0] lfsr_next(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    function automatic logic ks_after(input logic [6:0] s0, input int k);
        logic [6:0] s = s0;
        for (int j = 0; j < k; j++) s = lfsr_next(s);
        return s[0];
    endfunction

    // tick enable every second cycle, keystream model, strobe counters
    always @(posedge clk) begin
        tick_ph <= ~tick_ph;
        if (tick_ph) ts_now <= ts_now + 1'b1;
        if (!rst && ks_adv) begin
            ks_lfsr <= lfsr_next(ks_lfsr);
            adv_cnt <= adv_cnt + 1;
        end
        if (!rst && done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ts(input logic [TS_W-1:0] t);
        do @(negedge clk); while (ts_now != t);
    endtask

    task automatic run_frame(input logic [FW-1:0] fr, input int len, input bit ack,
                             input int late, input bit poke);
        logic [6:0]      s0;
        logic [TS_W-1:0] t0;
        int a0, d0, nb, exp_adv;
        logic expb;
        while (busy) @(negedge clk);
        @(negedge clk);
        req_eof_ts = ts_now - TS_W'(late);
        req_frame  = fr;
        req_len    = LW'(len);
        req_ack    = ack;
        req_valid  = 1'b1;
        s0 = ks_lfsr;
        a0 = adv_cnt;
        d0 = done_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        t0 = req_eof_ts + TS_W'(ack ? 758 : 70);
        nb = ack ? 1 : len;
        exp_adv = ack ? 36 : 2 + len;
        wait_ts(t0 - 1'b1);
        chk(mod_en == 1'b0, ack ? "R7 quiet before ack slot" : "R2 quiet before first slot",
            int'(mod_en), 0);
        for (int i = 0; i < nb; i++) begin
            expb = ack ? 1'b1 : (fr[i] ^ ks_after(s0, 2 + i));
            wait_ts(t0 + TS_W'(21 * i + 1));
            chk(mod_en == expb, ack ? "R7 ack bit high" : "R4 whitened bit at slot start",
                int'(mod_en), int'(expb));
            if (poke && i == 1) begin
                req_frame = ~fr;
                req_ack   = ~ack;
                req_len   = LW'(3);
                req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
            wait_ts(t0 + TS_W'(21 * i + 20));
            chk(mod_en == expb, "R3 bit held to slot end", int'(mod_en), int'(expb));
        end
        wait_ts(t0 + TS_W'(21 * nb + 1));
        chk(mod_en == 1'b0, "R6 modulation off after frame", int'(mod_en), 0);
        chk(busy == 1'b0, "R8 busy cleared after frame", int'(busy), 0);
        chk(done_cnt - d0 == 1, len == 0 && !ack ? "R9 done for empty frame" : "R6 single done",
            done_cnt - d0, 1);
        chk(adv_cnt - a0 == exp_adv,
            ack ? "R7 ack advance count" : (len == 0 ? "R9 gap-only advances" : "R5 advance count"),
            adv_cnt - a0, exp_adv);
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'h1D5A);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mod_en == 0, "R1 mod_en low", int'(mod_en), 0);
        chk(busy == 0, "R1 busy low", int'(busy), 0);
        chk(done == 0, "R1 done low", int'(done), 0);
        chk(ks_adv == 0, "R1 ks_adv low", int'(ks_adv), 0);
        // directed corners
        run_frame(32'h0, 0, 1'b0, 0, 1'b0);            // R9
        run_frame(32'hFFFF_FFFF, 23, 1'b0, 2, 1'b0);   // R2 R3 R4 R5
        run_frame(32'h0000_0000, 6, 1'b0, 0, 1'b0);
        run_frame(32'hDEAD_BEEF, 1, 1'b1, 1, 1'b0);    // R7
        run_frame(32'h0000_2A5C, 14, 1'b0, 3, 1'b1);   // R8 ignored request
        run_frame(32'h0, 1, 1'b1, 0, 1'b1);            // R8 during ack
        run_frame(32'hFFFF_FFFF, 32, 1'b0, 0, 1'b0);
        // constrained random
        for (int n = 0; n < 20; n++) begin
            run_frame($urandom, int'($urandom_range(0, 23)), ($urandom_range(0, 4) == 0),
                      int'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule